// File: doc/BRIEF.md
# Digit-Serial Modular Polynomial Multiplier

This block forms the product of two polynomials whose coefficients are residues modulo a prime `P`. The product is reduced modulo a monic polynomial of degree `N`. The reduction is described by the coefficients `r(x)` of `x^N` rewritten modulo that polynomial, so `x^N = sum r_j x^j`. Each coefficient is an `M`-bit field.

A start strobe loads operand `a` into a rotating coefficient register and clears the accumulator. The block then runs `N` Horner steps, one per clock, consuming the coefficients of `a` from the highest degree down. In each step, every accumulator coefficient is updated in parallel:

`z'[j] = z[j-1] + z[N-1]*r[j] + a_cur*b[j]  (mod P)`, where `z[-1] = 0`.

A one-cycle done pulse marks the result. Operands `b` and `r` are read directly from the ports in every step, so they must be held stable while the block is busy. All inputs must already be reduced, with every coefficient below `P`.

Top module: `polyMulModP`

## Requirements
- R1: Every `M`-bit coefficient of `zOut` is always below `P`, given inputs whose coefficients are all below `P`.
- R2: If `start` is sampled at clock edge k while idle, `done` is high for exactly one cycle, following edge k+N, and is low otherwise.
- R3: When `done` is high, `zOut` equals a(x)·b(x) reduced by x^N = r(x), with all arithmetic modulo `P`. Coefficient j of each bus sits at bits [j*M +: M].
- R4: The accumulator is cleared by an accepted start, so `zOut` reads all zero in the cycle after the accepted edge, whatever a previous run left behind.
- R5: A `start` raised while busy is ignored: the running operation keeps its timing and its result, even when `aIn` has changed.
- R6: `busy` is high from the edge that accepts `start` until the edge of the last step, and low otherwise.
- R7: While `rstN` is low, and in the cycle after it is released, `zOut` is zero and `busy` and `done` are low. This also holds when reset interrupts a running operation.
- R8: Coefficients of `a` are consumed highest degree first, so after the first step `zOut` equals a[N-1]·b(x) mod `P`, coefficient by coefficient.
- R9: After `done`, `zOut` holds its value while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication (accepted only while idle) |
| aIn | input | N*M | Operand a(x), sampled at the accepted start |
| bIn | input | N*M | Operand b(x), held stable while busy |
| rIn | input | N*M | Coefficients of x^N modulo the reduction polynomial, held stable while busy |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: result valid |
| zOut | output | N*M | Accumulator / result z(x) |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a run. The bench raises `start` two steps into an operation and at the same moment swaps `aIn` for a different operand. A design that restarted or reloaded would then show a late `done` or a wrong product.

The bench also samples `zOut` after the very first step. This proves the highest-degree coefficient of `a` is consumed first, which a final result can hide when `a` is symmetric.

The vector table includes `a = 1`, `a = x^(N-1)`, all-maximal coefficients and a zero reduction polynomial. Between them, these exercise the fold path and the two-stage modular correction at their extremes.

// File: rtl/polyMulPkg.sv
package polyMulPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture a, clear accumulator
    logic step;   // one Horner step
  } polyCtrlT;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } polyStateT;

endpackage

// File: rtl/polyMulModMul.sv
module polyMulModMul #(
  parameter int M = 4,
  parameter int P = 13
) (
  input  logic [M-1:0] x,
  input  logic [M-1:0] y,
  output logic [M-1:0] prodMod
);
  localparam int W = 2 * M;
  localparam logic [W-1:0] PW = W'(P);

  logic [W-1:0] prodFull;

  always_comb begin
    prodFull = W'(x) * W'(y);
    prodMod  = M'(prodFull % PW);
  end
endmodule

// File: rtl/polyMulCtrl.sv
module polyMulCtrl
  import polyMulPkg::*;
#(
  parameter int N = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output polyCtrlT ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  polyStateT     state;
  logic [CW-1:0] stepCnt;
  logic          lastStep;

  always_comb begin
    lastStep  = (state == ST_RUN) && (stepCnt == LAST);
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
    busy      = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= lastStep;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          if (lastStep) state <= ST_IDLE;
          stepCnt <= stepCnt + CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: an accepted start makes the block busy
  assert_load_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> busy);

  // R6: load and step never coincide
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.load, ctrl.step}));

  // R5: start while busy does not disturb the step sequence
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastStep) |=> (busy && stepCnt == $past(stepCnt) + CW'(1)));
endmodule

// File: rtl/polyMulDatapath.sv
module polyMulDatapath
  import polyMulPkg::*;
#(
  parameter int N = 4,
  parameter int M = 4,
  parameter int P = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  polyCtrlT      ctrl,
  input  logic [N*M-1:0] aIn,
  input  logic [N*M-1:0] bIn,
  input  logic [N*M-1:0] rIn,
  output logic [N*M-1:0] zOut
);
  localparam int SW = M + 2;
  localparam logic [SW-1:0] PS = SW'(P);
  localparam logic [M-1:0]  PM = M'(P);

  logic [N*M-1:0] aReg;
  logic [N*M-1:0] zReg;
  logic [N*M-1:0] zNext;
  logic [M-1:0]   aCur;
  logic [M-1:0]   zTop;

  assign aCur = aReg[(N-1)*M +: M];
  assign zTop = zReg[(N-1)*M +: M];
  assign zOut = zReg;

  for (genvar j = 0; j < N; j++) begin : g_cell
    logic [M-1:0]  zPrev;
    logic [M-1:0]  foldTerm;
    logic [M-1:0]  mulTerm;
    logic [SW-1:0] sumRaw;
    logic [SW-1:0] sumOnce;
    logic [SW-1:0] sumTwice;

    if (j == 0) begin : g_low
      assign zPrev = '0;
    end else begin : g_up
      assign zPrev = zReg[(j-1)*M +: M];
    end

    polyMulModMul #(.M(M), .P(P)) u_fold (
      .x(zTop), .y(rIn[j*M +: M]), .prodMod(foldTerm)
    );
    polyMulModMul #(.M(M), .P(P)) u_mul (
      .x(aCur), .y(bIn[j*M +: M]), .prodMod(mulTerm)
    );

    always_comb begin
      sumRaw   = SW'(zPrev) + SW'(foldTerm) + SW'(mulTerm);
      sumOnce  = (sumRaw  >= PS) ? sumRaw  - PS : sumRaw;
      sumTwice = (sumOnce >= PS) ? sumOnce - PS : sumOnce;
      zNext[j*M +: M] = sumTwice[M-1:0];
    end

    // R1: each accumulator coefficient stays a reduced residue
    assert_coef_range_R1: assert property (@(posedge clk) disable iff (!rstN)
      zReg[j*M +: M] < PM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0;
      zReg <= '0;
    end else if (ctrl.load) begin
      aReg <= aIn;
      zReg <= '0;
    end else if (ctrl.step) begin
      aReg <= {aReg[(N-1)*M-1:0], aReg[N*M-1 -: M]};
      zReg <= zNext;
    end
  end

  // R4: accumulator is zero right after a load
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (zOut == '0));

  // R8: the highest-degree coefficient of a is presented first
  assert_msb_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (aCur == $past(aIn[(N-1)*M +: M])));

  // R9: accumulator is frozen when no strobe is active
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> $stable(zOut));
endmodule

// File: rtl/polyMulModP.sv
module polyMulModP
  import polyMulPkg::*;
#(
  parameter int N = 4,
  parameter int M = 4,
  parameter int P = 13
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N*M-1:0] aIn,
  input  logic [N*M-1:0] bIn,
  input  logic [N*M-1:0] rIn,
  output logic           busy,
  output logic           done,
  output logic [N*M-1:0] zOut
);
  polyCtrlT ctrl;

  polyMulCtrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  polyMulDatapath #(.N(N), .M(M), .P(P)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .aIn(aIn), .bIn(bIn), .rIn(rIn), .zOut(zOut)
  );
endmodule

// File: tb/polyMulModP_tb.sv
module polyMulModP_tb;
  localparam int N = 4;
  localparam int M = 4;
  localparam int P = 13;
  localparam int NV = 7;

  typedef struct packed {
    logic [N*M-1:0] a;
    logic [N*M-1:0] b;
    logic [N*M-1:0] r;
  } vecT;

  // Coefficient j at bits [j*M +: M]; every nibble below 13
  localparam vecT VECS [NV] = '{
    '{16'h1234, 16'h0561, 16'h0203},
    '{16'hCCCC, 16'hCCCC, 16'hCCCC},
    '{16'h0001, 16'h9A7B, 16'h0105},
    '{16'h1000, 16'h0B3C, 16'h0C01},
    '{16'h0000, 16'hABCA, 16'h1111},
    '{16'h5A0C, 16'hC0B7, 16'h0000},
    '{16'h7777, 16'h3021, 16'hC5A2}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N*M-1:0] aIn = '0;
  logic [N*M-1:0] bIn = '0;
  logic [N*M-1:0] rIn = '0;
  logic           busy;
  logic           done;
  logic [N*M-1:0] zOut;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  polyMulModP #(.N(N), .M(M), .P(P)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .aIn(aIn), .bIn(bIn), .rIn(rIn),
    .busy(busy), .done(done), .zOut(zOut)
  );

  function automatic logic [N*M-1:0] refMul(input logic [N*M-1:0] a,
                                            input logic [N*M-1:0] b,
                                            input logic [N*M-1:0] r);
    int c [2*N-1];
    logic [N*M-1:0] res;
    for (int k = 0; k < 2*N-1; k++) c[k] = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        c[i+j] = (c[i+j] + int'(a[i*M +: M]) * int'(b[j*M +: M])) % P;
    for (int k = 2*N-2; k >= N; k--) begin
      int t;
      t = c[k];
      c[k] = 0;
      for (int j = 0; j < N; j++)
        c[k-N+j] = (c[k-N+j] + t * int'(r[j*M +: M])) % P;
    end
    res = '0;
    for (int k = 0; k < N; k++) res[k*M +: M] = M'(c[k]);
    return res;
  endfunction

  function automatic logic [N*M-1:0] firstStep(input logic [N*M-1:0] a,
                                               input logic [N*M-1:0] b);
    logic [N*M-1:0] res;
    int top;
    top = int'(a[(N-1)*M +: M]);
    for (int k = 0; k < N; k++)
      res[k*M +: M] = M'((top * int'(b[k*M +: M])) % P);
    return res;
  endfunction

  function automatic bit inRange(input logic [N*M-1:0] z);
    for (int k = 0; k < N; k++)
      if (int'(z[k*M +: M]) >= P) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation from the current negedge; optionally injects a
  // start with a different a two steps in (R5).
  task automatic runOp(input vecT v, input bit intrude);
    logic [N*M-1:0] expZ;
    logic [N*M-1:0] held;
    expZ = refMul(v.a, v.b, v.r);
    aIn = v.a; bIn = v.b; rIn = v.r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 clear", 64'(zOut), 64'(0));
    check("R6 busy after accept", {63'd0, busy}, 64'd1);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 1) check("R8 first step", 64'(zOut), 64'(firstStep(v.a, v.b)));
      if (i < N) begin
        check("R2 no early done", {63'd0, done}, 64'd0);
        check("R6 busy mid", {63'd0, busy}, 64'd1);
      end
      if (intrude && i == 2) begin
        start = 1'b1;
        aIn = ~v.a & {N{4'h7}};
      end
    end
    check("R2 done", {63'd0, done}, 64'd1);
    check("R6 idle at done", {63'd0, busy}, 64'd0);
    check(intrude ? "R5 result" : "R3 result", 64'(zOut), 64'(expZ));
    check("R1 range", {63'd0, inRange(zOut)}, 64'd1);
    held = zOut;
    @(negedge clk);
    check("R2 single pulse", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R9 hold", 64'(zOut), 64'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R7 reset z", 64'(zOut), 64'(0));
    check("R7 reset busy/done", {62'd0, busy, done}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset", {62'd0, busy, done}, 64'd0);

    for (int k = 0; k < NV; k++) runOp(VECS[k], 1'b0);

    runOp(VECS[6], 1'b1);
    runOp(VECS[0], 1'b1);

    // R7: reset in the middle of a run
    aIn = VECS[1].a; bIn = VECS[1].b; rIn = VECS[1].r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R7 mid-run reset z", 64'(zOut), 64'(0));
    check("R7 mid-run reset flags", {62'd0, busy, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 idle after release", {62'd0, busy, done}, 64'd0);

    runOp(VECS[2], 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule